// File: doc/BRIEF.md
# Four-Pin GPIO Set/Clear Control Register

This block holds the output state of four general-purpose pins and reports their input state, all through a single 32-bit register word. Pin output data and output direction each have a pair of fields in the word. One field of each pair sets bits and the other clears them, so software changes only the pins it names and needs no read-modify-write. The surrounding logic decodes the address and the bus protocol. It hands the block a write strobe with a full 32-bit word, or a read strobe, and receives the readback word in the same cycle.

Toward the pad ring, the block drives a 4-bit output value and a 4-bit output enable. A pin whose enable is clear is tristated, and the block also forces its output value to 0. The raw pin levels pass through a multi-flop synchronizer, and the top nibble of the readback word shows the synchronized values.

Top module: `gpiosc_top`

## Requirements
- R1: On a write, each 1 in bits 11:8 clears the matching stored output data bit. A 0 there leaves that bit unchanged.
- R2: On a write, each 1 in bits 15:12 sets the matching stored output data bit. A 0 there leaves that bit unchanged.
- R3: On a write, each 1 in bits 19:16 clears the matching output enable, which tristates that pin. A 0 there leaves the enable unchanged.
- R4: On a write, each 1 in bits 23:20 sets the matching output enable. A 0 there leaves the enable unchanged.
- R5: If one write has a 1 in both the set bit and the clear bit of the same pin, in either pair, that stored bit ends up clear.
- R6: `pin_oe` equals the stored enables. `pin_out` equals the stored data ANDed with the stored enables, so a pin whose enable is clear is never driven.
- R7: A write changes `pin_out` and `pin_oe` from the first clock edge that samples `wr_en`, so the new values are visible in the following cycle. With no write, the stored state does not change.
- R8: After reset, the stored data and the enables are all 0.
- R9: While `rd_en` is high, read bits 27:24 and 7:0 are 0. While `rd_en` is low, the whole of `rd_data` is 0.
- R10: While `rd_en` is high, read bits 11:8 and bits 15:12 both return the stored data, and bits 19:16 and bits 23:20 both return the stored enables.
- R11: While `rd_en` is high, read bits 31:28 return `pin_in` delayed by SYNC_STAGES clock edges (2 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write word holding the set and clear fields |
| rd_en | input | 1 | Read strobe; gates the readback word |
| rd_data | output | 32 | Readback word |
| pin_in | input | 4 | Raw pin levels from the pads |
| pin_out | output | 4 | Output value toward the pad drivers |
| pin_oe | output | 4 | Output enable toward the pad drivers, 1 = drive |

## Verification
The bench builds the block with its default of two synchronizer stages and four pins. That configuration is small enough to sweep completely. For every one of the 16 starting states it applies all 256 set/clear combinations to both the data pair and the enable pair, so the clear-priority case and the unchanged-by-zero case are reached for every pin. It also steps `pin_in` through all 16 values and checks that the input field shows no change after one edge and shows the new value after two edges.

// File: rtl/gpiosc_pkg.sv
package gpiosc_pkg;
    localparam int PIN_W       = 4;
    localparam int WORD_W      = 32;
    localparam int DAT_CLR_LSB = 8;
    localparam int DAT_SET_LSB = 12;
    localparam int OE_CLR_LSB  = 16;
    localparam int OE_SET_LSB  = 20;
    localparam int RSV_LSB     = 24;
    localparam int IN_LSB      = 28;

    typedef struct packed {
        logic [PIN_W-1:0] dat;
        logic [PIN_W-1:0] oe;
    } gpiosc_state_t;
endpackage

// File: rtl/gpiosc_sync.sv
module gpiosc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpiosc_bank.sv
module gpiosc_bank
    import gpiosc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output gpiosc_state_t     state_o
);
    gpiosc_state_t state_d, state_q;
    logic [PIN_W-1:0] dat_set, dat_clr, oe_set, oe_clr;

    assign dat_clr = wr_word[DAT_CLR_LSB +: PIN_W];
    assign dat_set = wr_word[DAT_SET_LSB +: PIN_W];
    assign oe_clr  = wr_word[OE_CLR_LSB  +: PIN_W];
    assign oe_set  = wr_word[OE_SET_LSB  +: PIN_W];

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.dat = (state_q.dat | dat_set) & ~dat_clr;
            state_d.oe  = (state_q.oe  | oe_set)  & ~oe_clr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((state_q.dat & $past(dat_clr)) == '0) && ((state_q.oe & $past(oe_clr)) == '0));
    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((state_q.dat & $past(dat_set & ~dat_clr)) == $past(dat_set & ~dat_clr)));
    assert_oe_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((state_q.oe & $past(oe_set & ~oe_clr)) == $past(oe_set & ~oe_clr)));
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state_q));
endmodule

// File: rtl/gpiosc_top.sv
module gpiosc_top
    import gpiosc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    gpiosc_state_t    state;
    logic [PIN_W-1:0] pin_sync;
    logic [WORD_W-1:0] word;

    gpiosc_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word (wr_data),
        .state_o (state)
    );

    gpiosc_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    always_comb begin
        word = '0;
        word[DAT_CLR_LSB +: PIN_W] = state.dat;
        word[DAT_SET_LSB +: PIN_W] = state.dat;
        word[OE_CLR_LSB  +: PIN_W] = state.oe;
        word[OE_SET_LSB  +: PIN_W] = state.oe;
        word[IN_LSB      +: PIN_W] = pin_sync;
    end

    assign rd_data = rd_en ? word : '0;
    assign pin_oe  = state.oe;
    assign pin_out = state.dat & state.oe;

    assert_no_drive_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);
    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[RSV_LSB +: PIN_W] == '0) && (rd_data[7:0] == '0));
    assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));
endmodule

// File: tb/gpiosc_top_tb_top.sv
module gpiosc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [3:0]  pin_in = '0;
    logic [3:0]  pin_out, pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] exp_dat = '0;
    logic [3:0] exp_oe  = '0;

    always #4 clk = ~clk;

    gpiosc_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] ds, input logic [3:0] dc,
                            input logic [3:0] os, input logic [3:0] oc);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {8'h00, os, oc, ds, dc, 8'h00};
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        exp_dat = (exp_dat | ds) & ~dc;
        exp_oe  = (exp_oe  | os) & ~oc;
    endtask

    task automatic check_state(input string req);
        logic [31:0] exp_word;
        rd_en = 1'b1;
        #1;
        exp_word = {rd_data[31:28], 4'h0, exp_oe, exp_oe, exp_dat, exp_dat, 8'h00};
        check({req, " R10 R9 readback"}, rd_data, exp_word);
        check({req, " R6 pin_oe"}, {28'h0, pin_oe}, {28'h0, exp_oe});
        check({req, " R6 pin_out"}, {28'h0, pin_out}, {28'h0, exp_dat & exp_oe});
        rd_en = 1'b0;
        #1;
        check("R9 idle read", rd_data, 32'h0);
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check_state("R8 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R8 after release");

        // R1 R2 R3 R4 R5: full sweep of start state and set/clear nibbles
        for (int st = 0; st < 16; st++) begin
            for (int sc = 0; sc < 256; sc++) begin
                do_write(st[3:0], ~st[3:0], st[3:0] ^ 4'h5, ~(st[3:0] ^ 4'h5));
                do_write(sc[7:4], sc[3:0], sc[3:0], sc[7:4]);
                check_state("R1 R2 R3 R4 R5 sweep");
            end
        end

        // R7: output visible in the cycle right after the write edge
        do_write(4'h0, 4'hF, 4'hF, 4'h0);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = {8'h00, 4'h0, 4'h0, 4'hA, 4'h0, 8'h00};
        @(posedge clk);
        #1;
        check("R7 updated after write edge", {28'h0, pin_out}, 32'hA);
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 32'hFFFF_FFFF;
        exp_dat = 4'hA;
        exp_oe  = 4'hF;
        repeat (3) @(negedge clk);
        check_state("R7 hold without strobe");
        wr_data = '0;

        // R11: input field latency over all pin values
        for (int v = 0; v < 16; v++) begin
            logic [3:0] prev;
            prev = pin_in;
            @(negedge clk);
            pin_in = v[3:0];
            rd_en = 1'b1;
            @(negedge clk);
            check("R11 one edge later still old", {28'h0, rd_data[31:28]}, {28'h0, prev});
            @(negedge clk);
            check("R11 two edges later new", {28'h0, rd_data[31:28]}, {28'h0, v[3:0]});
            check("R9 reserved bits", {24'h0, rd_data[27:24], rd_data[7:4]}, 32'h0);
            rd_en = 1'b0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule